// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line back into parallel characters. The block's clock runs at sixteen times the bit rate. A two-flop synchronizer brings in the line, and the receiver starts a frame on a falling edge of the line. The start bit is checked at its centre. Each data bit, the optional parity bit and the first stop bit are then sampled once per sixteen clocks at the same centre phase. The finished character is copied into a buffer register, right-justified. Three flags qualify the character: parity, framing and overrun.

A control register holds the character length, the parity enable and the parity sense. The register is written only while a load strobe is high, so the same control word can be shared with a companion transmitter. Software or a neighbour acknowledges each character by pulling the active-low data-received reset. Two enables force the character outputs and the status outputs to zero when they are not selected.

Top module: `uart_rx_core`

## Requirements
- R1: While `rst_n` is low and after reset, `rx_data`, `data_ready`, `par_err`, `frm_err` and `ovr_err` read zero. The control register resets to 8 data bits with parity off.
- R2: A falling edge on the synchronized `rxd` starts a frame. If the line is high again at the start-bit centre (8 clocks after detection), the receiver returns to hunting and changes neither data nor flags.
- R3: Data bits arrive LSB first. `cfg_len` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 bits. The character is right-justified in `rx_data`, and the unused upper bits read zero.
- R4: Each completed frame sets `data_ready` during its first stop bit. A low on `dr_clr_n` clears `data_ready` in any cycle without a transfer.
- R5: With parity on, one parity bit follows the data. `cfg_par_even`=1 means the data plus parity hold an even number of ones, and 0 means odd. On a mismatch `par_err` is set, and it clears on a later character whose parity matches.
- R6: With `cfg_par_off`=1, no parity bit is expected and `par_err` is low.
- R7: `frm_err` is set when the first stop bit is sampled low. It stays set until a later character brings a high stop bit.
- R8: `ovr_err` is set when `data_ready` is still high as a new character is transferred. It clears at the next transfer if `data_ready` was cleared in between.
- R9: `rbuf_oe`=0 forces `rx_data` to zero. `flag_oe`=0 forces the four status outputs to zero. Neither enable changes any stored state.
- R10: The `cfg_*` inputs are taken only on cycles where `cfg_load` is high, and are ignored otherwise.
- R11: Start-bit hunting resumes within the first stop bit, so frames sent back to back with a single stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16x the bit rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| rxd | input | 1 | Asynchronous serial line, idles high |
| cfg_load | input | 1 | High loads the control register |
| cfg_len | input | 2 | Length code: 5 + code data bits |
| cfg_par_off | input | 1 | 1 disables parity |
| cfg_par_even | input | 1 | 1 selects even parity, 0 odd |
| dr_clr_n | input | 1 | Active-low data-received reset |
| rbuf_oe | input | 1 | Enables the character outputs |
| flag_oe | input | 1 | Enables the status outputs |
| rx_data | output | 8 | Received character, right-justified |
| data_ready | output | 1 | Character available |
| par_err | output | 1 | Parity mismatch on last character |
| frm_err | output | 1 | Low first stop bit on last character |
| ovr_err | output | 1 | Character arrived before acknowledge |

## Verification
The assertions watch the transfer handshake on every cycle. After a transfer, `data_ready` must be set. A clear without a transfer must drop it. The overrun and framing flags may change only at a transfer. A glitch start must return the sequencer to hunting, the bit index must stay within the programmed length, and parity off must never produce a parity error.

Only the bench's scenarios can show that whole characters are reassembled correctly. It sweeps every length and parity mode with several patterns, and it exercises persistence over sequences of characters, the output enables, control-register isolation and back-to-back frames.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes a fixed 8-bit maximum character width.
package uart_rx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_TAIL
    } rx_state_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_off;
        logic       par_even;
    } rx_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Synchronizer and falling-edge detector for the serial line.
// Assumes the line idles high, so all stages reset to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the line through the chain and keep the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = last & ~dout;
endmodule

// File: rtl/uart_rx_frame.sv
// Frame sequencer: finds the start bit, samples each bit at its centre
// and presents a one-cycle transfer with the character and error results.
// Assumes the control word is stable while a frame is in progress.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int TAIL_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              rx_fall,
    input  rx_cfg_t           cfg,
    output logic              xfer,
    output logic [DATA_W-1:0] xfer_data,
    output logic              xfer_perr,
    output logic              xfer_ferr
);
    localparam int CW     = $clog2(OVERSAMPLE);
    localparam int CENTER = OVERSAMPLE / 2 - 1;
    localparam int LAST   = OVERSAMPLE - 1;

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bitidx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic [2:0]        last_idx;
    logic [1:0]        rshift;
    logic              stop_hit;

    assign last_idx = 3'd4 + {1'b0, cfg.len_code};
    assign rshift   = 2'd3 - cfg.len_code;
    assign stop_hit = (state == ST_STOP) && (cnt == CW'(LAST));

    // Sequence one frame from start detection to the hunt restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            bitidx    <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            xfer      <= 1'b0;
            xfer_data <= '0;
            xfer_perr <= 1'b0;
            xfer_ferr <= 1'b0;
        end else begin
            xfer <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (rx_fall) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == CW'(CENTER)) begin
                        cnt <= '0;
                        if (rx_s) begin
                            state <= ST_HUNT;
                        end else begin
                            state   <= ST_DATA;
                            bitidx  <= '0;
                            par_acc <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == CW'(LAST)) begin
                        cnt     <= '0;
                        shreg   <= {rx_s, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ rx_s;
                        if (bitidx == last_idx) begin
                            state <= cfg.par_off ? ST_STOP : ST_PAR;
                        end else begin
                            bitidx <= bitidx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == CW'(LAST)) begin
                        cnt     <= '0;
                        par_acc <= par_acc ^ rx_s;
                        state   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (stop_hit) begin
                        cnt       <= '0;
                        xfer      <= 1'b1;
                        xfer_data <= shreg >> rshift;
                        xfer_perr <= ~cfg.par_off & (cfg.par_even ? par_acc : ~par_acc);
                        xfer_ferr <= ~rx_s;
                        state     <= ST_TAIL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == CW'(TAIL_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    AST_GLITCH_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && cnt == CW'(CENTER) && rx_s) |=> (state == ST_HUNT)); // R2
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bitidx <= last_idx)); // R3
    AST_PAR_OFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && cfg.par_off) |=> (xfer && !xfer_perr)); // R6
    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer); // R11
endmodule

// File: rtl/uart_rx_status.sv
// Buffer register and status flags, updated on each character transfer.
// Assumes xfer is a single-cycle strobe; a transfer wins over a clear.
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_perr,
    input  logic              xfer_ferr,
    input  logic              dr_clr_n,
    output logic [DATA_W-1:0] rbuf,
    output logic              dr,
    output logic              perr,
    output logic              ferr,
    output logic              oerr
);
    // Load the character and flags on transfer, otherwise honour the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf <= '0;
            dr   <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            oerr <= 1'b0;
        end else if (xfer) begin
            rbuf <= xfer_data;
            dr   <= 1'b1;
            perr <= xfer_perr;
            ferr <= xfer_ferr;
            oerr <= dr & dr_clr_n;
        end else if (!dr_clr_n) begin
            dr <= 1'b0;
        end
    end

    AST_DR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> dr); // R4
    AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!dr_clr_n && !xfer) |=> !dr); // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && dr && dr_clr_n) |=> oerr); // R8
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(oerr)); // R8
    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(ferr)); // R7
endmodule

// File: rtl/uart_rx_core.sv
// Top of the serial receiver: control register, synchronizer, frame
// sequencer, status/buffer and output enables.
// Assumes clk runs at OVERSAMPLE times the bit rate.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_off,
    input  logic              cfg_par_even,
    input  logic              dr_clr_n,
    input  logic              rbuf_oe,
    input  logic              flag_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    rx_cfg_t           cfg_q;
    logic              rx_s, rx_fall;
    logic              xfer, xfer_perr, xfer_ferr;
    logic [DATA_W-1:0] xfer_data, rbuf;
    logic              dr, perr, ferr, oerr;

    // Hold the control word; take it only while the load strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{len_code: 2'b11, par_off: 1'b1, par_even: 1'b0};
        end else if (cfg_load) begin
            cfg_q <= '{len_code: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even};
        end
    end

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s), .fall(rx_fall)
    );

    uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .TAIL_CYC(1)) i_frame (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_fall(rx_fall), .cfg(cfg_q),
        .xfer(xfer), .xfer_data(xfer_data), .xfer_perr(xfer_perr), .xfer_ferr(xfer_ferr)
    );

    uart_rx_status i_status (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .xfer_data(xfer_data),
        .xfer_perr(xfer_perr), .xfer_ferr(xfer_ferr), .dr_clr_n(dr_clr_n),
        .rbuf(rbuf), .dr(dr), .perr(perr), .ferr(ferr), .oerr(oerr)
    );

    assign rx_data    = rbuf_oe ? rbuf : '0;
    assign data_ready = flag_oe & dr;
    assign par_err    = flag_oe & perr;
    assign frm_err    = flag_oe & ferr;
    assign ovr_err    = flag_oe & oerr;
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_off = 1'b1;
    logic       cfg_par_even = 1'b0;
    logic       dr_clr_n = 1'b1;
    logic       rbuf_oe = 1'b1;
    logic       flag_oe = 1'b1;
    logic [7:0] rx_data;
    logic       data_ready, par_err, frm_err, ovr_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int         cur_n = 8;
    logic       cur_off = 1'b1;
    logic       cur_even = 1'b0;

    always #10 clk = ~clk;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_load(cfg_load), .cfg_len(cfg_len),
        .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even), .dr_clr_n(dr_clr_n),
        .rbuf_oe(rbuf_oe), .flag_oe(flag_oe), .rx_data(rx_data), .data_ready(data_ready),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input logic off, input logic even);
        @(negedge clk);
        cfg_len = 2'(len - 5); cfg_par_off = off; cfg_par_even = even; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cur_n = len; cur_off = off; cur_even = even;
    endtask

    task automatic clear_dr();
        @(negedge clk); dr_clr_n = 1'b0;
        @(negedge clk); dr_clr_n = 1'b1;
    endtask

    function automatic logic [7:0] mask(input logic [7:0] d);
        return d & 8'((9'd1 << cur_n) - 9'd1);
    endfunction

    // Send one frame per the bench's view of the config; bit time is 16 clocks.
    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop, input int idle);
        logic [7:0] m;
        logic pbit;
        m = mask(d);
        pbit = cur_even ? ^m : ~(^m);
        @(negedge clk); rxd = 1'b0; hold(15);
        for (int i = 0; i < cur_n; i++) begin
            @(negedge clk); rxd = m[i]; hold(15);
        end
        if (!cur_off) begin
            @(negedge clk); rxd = pbit ^ bad_par; hold(15);
        end
        @(negedge clk); rxd = stop; hold(15);
        if (!stop || idle > 0) begin
            @(negedge clk); rxd = 1'b1;
            hold(stop ? idle : 32);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
        logic [7:0] held;
        hold(4);
        // R1: reset state
        chk("R1 rx_data", 32'(rx_data), 0);
        chk("R1 flags", {28'd0, data_ready, par_err, frm_err, ovr_err}, 0);
        @(negedge clk); rst_n = 1'b1;
        hold(4);
        chk("R1 after reset", {20'd0, rx_data, data_ready, par_err, frm_err, ovr_err}, 0);
        // R1: reset config is 8 bits, parity off
        send(8'hC3, 1'b0, 1'b1, 4);
        chk("R1 default cfg data", 32'(rx_data), 32'hC3);
        chk("R1 default cfg flags", {29'd0, par_err, frm_err, ovr_err}, 0);

        // R3 R5 R6 R4: sweep lengths, parity modes and patterns
        for (int len = 5; len <= 8; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                set_cfg(len, mode == 0, mode == 1);
                for (int p = 0; p < 8; p++) begin
                    clear_dr();
                    chk("R4 cleared", 32'(data_ready), 0);
                    send(pats[p], 1'b0, 1'b1, 4);
                    chk("R3 data", 32'(rx_data), 32'(mask(pats[p])));
                    chk("R4 ready", 32'(data_ready), 1);
                    chk("R5 R6 parity", 32'(par_err), 0);
                    chk("R7 stop ok", 32'(frm_err), 0);
                    chk("R8 no overrun", 32'(ovr_err), 0);
                end
            end
        end

        // R5: bad parity sets, good parity clears (even and odd)
        set_cfg(8, 1'b0, 1'b1);
        clear_dr(); send(8'h37, 1'b1, 1'b1, 4);
        chk("R5 even mismatch", 32'(par_err), 1);
        chk("R5 data kept", 32'(rx_data), 32'h37);
        clear_dr(); send(8'h37, 1'b0, 1'b1, 4);
        chk("R5 even clears", 32'(par_err), 0);
        set_cfg(7, 1'b0, 1'b0);
        clear_dr(); send(8'h15, 1'b1, 1'b1, 4);
        chk("R5 odd mismatch", 32'(par_err), 1);
        // R6: switching parity off, next character reports no parity error
        set_cfg(7, 1'b1, 1'b0);
        clear_dr(); send(8'h15, 1'b0, 1'b1, 4);
        chk("R6 parity off", 32'(par_err), 0);

        // R7: framing error and its persistence
        set_cfg(8, 1'b1, 1'b0);
        clear_dr(); send(8'h5A, 1'b0, 1'b0, 0);
        chk("R7 low stop", 32'(frm_err), 1);
        hold(20);
        chk("R7 persists", 32'(frm_err), 1);
        clear_dr(); send(8'h66, 1'b0, 1'b1, 4);
        chk("R7 valid stop clears", 32'(frm_err), 0);

        // R8: overrun set, held, then cleared after acknowledge
        clear_dr(); send(8'h11, 1'b0, 1'b1, 4);
        send(8'h22, 1'b0, 1'b1, 4);
        chk("R8 overrun set", 32'(ovr_err), 1);
        chk("R8 newest data", 32'(rx_data), 32'h22);
        send(8'h33, 1'b0, 1'b1, 4);
        chk("R8 overrun stays", 32'(ovr_err), 1);
        clear_dr();
        chk("R8 held until transfer", 32'(ovr_err), 1);
        send(8'h44, 1'b0, 1'b1, 4);
        chk("R8 overrun clears", 32'(ovr_err), 0);

        // R9: enables gate outputs without touching state
        send(8'h55, 1'b0, 1'b1, 4);
        @(negedge clk); rbuf_oe = 1'b0; flag_oe = 1'b0;
        @(negedge clk);
        chk("R9 data gated", 32'(rx_data), 0);
        chk("R9 flags gated", {28'd0, data_ready, par_err, frm_err, ovr_err}, 0);
        rbuf_oe = 1'b1; flag_oe = 1'b1;
        @(negedge clk);
        chk("R9 state kept", {23'd0, rx_data, data_ready}, {23'd0, 8'h55, 1'b1});
        chk("R9 overrun kept", 32'(ovr_err), 1);

        // R2: glitch start is ignored
        clear_dr();
        held = rx_data;
        @(negedge clk); rxd = 1'b0; hold(2);
        @(negedge clk); rxd = 1'b1; hold(40);
        chk("R2 glitch ready", 32'(data_ready), 0);
        chk("R2 glitch data", 32'(rx_data), 32'(held));
        chk("R2 glitch flags", {29'd0, par_err, frm_err, ovr_err}, {29'd0, 3'b001});
        send(8'h96, 1'b0, 1'b1, 4);
        chk("R2 receive after glitch", 32'(rx_data), 32'h96);

        // R10: config inputs ignored without load
        @(negedge clk); cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_par_even = 1'b1;
        hold(2);
        clear_dr(); send(8'hA5, 1'b0, 1'b1, 4);
        chk("R10 cfg unchanged data", 32'(rx_data), 32'hA5);
        chk("R10 cfg unchanged parity", 32'(par_err), 0);

        // R11: back-to-back frames, single stop bit, no idle
        clear_dr();
        send(8'h81, 1'b0, 1'b1, 0);
        send(8'h7E, 1'b0, 1'b1, 4);
        chk("R11 second frame data", 32'(rx_data), 32'h7E);
        chk("R11 second frame overrun", 32'(ovr_err), 1);
        chk("R11 stop ok", 32'(frm_err), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule